// File: doc/BRIEF.md
# Turbo Iteration Controller with Permutation Table

This block runs the iterative exchange between the two constituent soft-in soft-out decoders of a parallel concatenated decoder. It keeps the extrinsic log-likelihood ratios of one block of `N_LEN` information bits in a local store. It feeds them to the decoders as a priori values and writes back what each decoder returns. Values travel to the second decoder through a loadable index permutation and return through its exact inverse. Each run performs a fixed number of full iterations, `N_ITER` (default 6), with no early exit. Both decoders share one trellis and one algorithm, so they share one streaming interface, and `sel_o` tells the external arithmetic which half-iteration is active.

Each half-iteration has two phases. In the first, the block streams `N_LEN` a priori values out, one per cycle. In the second, it accepts `N_LEN` returned beats, each carrying an extrinsic value and an a posteriori value; these beats may arrive with gaps. In the second half of the last iteration, the sign of each a posteriori value becomes a hard decision and is stored at its natural bit position. When the run finishes, the decisions stream out in natural order.

The permutation table must hold the same permutation the encoder used. A write port loads it while the block is idle, and reset loads the reversed order. Every run starts by scanning the table, and a duplicated index stops the run.

Top module: `turbo_iter_ctrl`

## Requirements
- R1: After reset, `busy_o`, `perm_err_o`, `ap_valid_o` and `dec_valid_o` are 0, and the table holds pi(i) = N_LEN-1-i.
- R2: A `start_i` sampled high while idle raises `busy_o` at the next edge. The first a priori beat follows after an N_LEN-cycle table scan. `start_i` has no effect while `busy_o` is high.
- R3: If the scan finds an index that occurs twice, the block sets `perm_err_o`, returns to idle without streaming anything, and clears the flag on the next accepted start.
- R4: In the first half (`sel_o`=0), the block streams N_LEN beats on consecutive cycles with `ap_idx_o` = 0..N_LEN-1. `ap_llr_o` is the stored extrinsic at address i, or 0 in the first iteration.
- R5: In the second half (`sel_o`=1), beat i carries the stored extrinsic at address pi(i), which interleaves the values.
- R6: Return beats are counted only when `ext_valid_i` is high during the return phase. Beat k of the first half is stored at address k, and beat k of the second half at pi(k), which deinterleaves them. `ext_valid_i` outside the return phase has no effect.
- R7: Exactly N_ITER iterations (2*N_ITER half-iterations) run. The cycle after the last return beat starts the decision output.
- R8: Decision i is 1 exactly when the two's-complement a posteriori value returned at beat k of the last second half is negative (MSB set), where pi(k)=i. Decisions stream with `dec_idx_o` = 0..N_LEN-1 on consecutive cycles, never alongside an a priori beat, and `busy_o` then falls.
- R9: Table writes while `busy_o` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| perm_we_i | input | 1 | Table write strobe |
| perm_addr_i | input | IDX_W | Table entry written |
| perm_data_i | input | IDX_W | Permuted index for that entry |
| start_i | input | 1 | Begin a decoding run |
| busy_o | output | 1 | Run in progress |
| perm_err_o | output | 1 | Last scan found a bad table |
| sel_o | output | 1 | 0 first decoder, 1 second decoder |
| ap_valid_o | output | 1 | A priori beat valid |
| ap_idx_o | output | IDX_W | Beat position |
| ap_llr_o | output | LLR_W | A priori LLR |
| ext_valid_i | input | 1 | Return beat valid |
| ext_llr_i | input | LLR_W | Extrinsic LLR |
| post_llr_i | input | LLR_W | A posteriori LLR |
| dec_valid_o | output | 1 | Decision beat valid |
| dec_idx_o | output | IDX_W | Decision bit position |
| dec_bit_o | output | 1 | Hard decision |

## Verification
The assertions assume that `start_i` is the only thing that wakes the block. They also assume the external decoder returns beats only after the a priori stream has ended. The bench drives start pulses only at idle and uses a permutation it has written itself. It also drives junk return beats during streaming and while busy, and those beats must leave both the stream and the decisions unchanged. Return data come from a fixed function of the a priori value, the beat, the iteration and the half. This lets the reference model predict every beat and every decision.

// File: rtl/turbo_ctrl_pkg.sv
package turbo_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEND,
    ST_RECV,
    ST_OUT
  } ctrl_state_e;
endpackage

// File: rtl/turbo_perm_table.sv
module turbo_perm_table #(
  parameter int N_LEN = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [IDX_W-1:0] rd_data_o,
  input  logic             scan_clr_i,
  input  logic             scan_en_i,
  output logic             bad_o
);
  logic [IDX_W-1:0] tab_q [N_LEN];
  logic [N_LEN-1:0] seen_q;
  logic             bad_q;
  logic             in_range;
  logic             hit;

  assign rd_data_o = tab_q[rd_addr_i];
  assign in_range  = {1'b0, rd_data_o} < (IDX_W+1)'(N_LEN);
  assign hit       = scan_en_i && (!in_range || seen_q[rd_data_o]);
  assign bad_o     = bad_q | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LEN; i++) tab_q[i] <= IDX_W'(N_LEN - 1 - i);
    end else if (wr_en_i) begin
      tab_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      bad_q  <= 1'b0;
    end else if (scan_clr_i) begin
      seen_q <= '0;
      bad_q  <= 1'b0;
    end else if (scan_en_i) begin
      if (in_range) seen_q[rd_data_o] <= 1'b1;
      bad_q <= bad_q | hit;
    end
  end
endmodule

// File: rtl/turbo_llr_store.sv
module turbo_llr_store #(
  parameter int N_LEN = 16,
  parameter int IDX_W = 4,
  parameter int LLR_W = 8
) (
  input  logic             clk_i,
  input  logic             ext_we_i,
  input  logic [IDX_W-1:0] ext_waddr_i,
  input  logic [LLR_W-1:0] ext_wdata_i,
  input  logic [IDX_W-1:0] ext_raddr_i,
  output logic [LLR_W-1:0] ext_rdata_o,
  input  logic             dec_we_i,
  input  logic [IDX_W-1:0] dec_waddr_i,
  input  logic             dec_wbit_i,
  input  logic [IDX_W-1:0] dec_raddr_i,
  output logic             dec_rbit_o
);
  logic [LLR_W-1:0] ext_mem [N_LEN];
  logic [N_LEN-1:0] dec_mem;

  assign ext_rdata_o = ext_mem[ext_raddr_i];
  assign dec_rbit_o  = dec_mem[dec_raddr_i];

  always_ff @(posedge clk_i) begin
    if (ext_we_i) ext_mem[ext_waddr_i] <= ext_wdata_i;
    if (dec_we_i) dec_mem[dec_waddr_i] <= dec_wbit_i;
  end
endmodule

// File: rtl/turbo_iter_ctrl.sv
module turbo_iter_ctrl
  import turbo_ctrl_pkg::*;
#(
  parameter int N_LEN  = 16,
  parameter int LLR_W  = 8,
  parameter int N_ITER = 6,
  localparam int IDX_W  = $clog2(N_LEN),
  localparam int ITER_W = (N_ITER > 1) ? $clog2(N_ITER) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             perm_we_i,
  input  logic [IDX_W-1:0] perm_addr_i,
  input  logic [IDX_W-1:0] perm_data_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             perm_err_o,
  output logic             sel_o,
  output logic             ap_valid_o,
  output logic [IDX_W-1:0] ap_idx_o,
  output logic [LLR_W-1:0] ap_llr_o,
  input  logic             ext_valid_i,
  input  logic [LLR_W-1:0] ext_llr_i,
  input  logic [LLR_W-1:0] post_llr_i,
  output logic             dec_valid_o,
  output logic [IDX_W-1:0] dec_idx_o,
  output logic             dec_bit_o
);
  ctrl_state_e       state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [ITER_W-1:0] iter_q;
  logic              half_q;
  logic              err_q;

  logic [IDX_W-1:0]  pi_val;
  logic [IDX_W-1:0]  mem_addr;
  logic [LLR_W-1:0]  mem_rdata;
  logic              scan_bad;
  logic              last_cnt, last_iter, ext_take, dec_take;

  assign last_cnt  = cnt_q == IDX_W'(N_LEN - 1);
  assign last_iter = iter_q == ITER_W'(N_ITER - 1);
  assign mem_addr  = half_q ? pi_val : cnt_q;  // second half goes through pi
  assign ext_take  = (state_q == ST_RECV) && ext_valid_i;
  assign dec_take  = ext_take && half_q && last_iter;

  turbo_perm_table #(.N_LEN(N_LEN), .IDX_W(IDX_W)) u_perm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (perm_we_i && (state_q == ST_IDLE)),
    .wr_addr_i  (perm_addr_i),
    .wr_data_i  (perm_data_i),
    .rd_addr_i  (cnt_q),
    .rd_data_o  (pi_val),
    .scan_clr_i ((state_q == ST_IDLE) && start_i),
    .scan_en_i  (state_q == ST_CHECK),
    .bad_o      (scan_bad)
  );

  turbo_llr_store #(.N_LEN(N_LEN), .IDX_W(IDX_W), .LLR_W(LLR_W)) u_store (
    .clk_i       (clk_i),
    .ext_we_i    (ext_take),
    .ext_waddr_i (mem_addr),
    .ext_wdata_i (ext_llr_i),
    .ext_raddr_i (mem_addr),
    .ext_rdata_o (mem_rdata),
    .dec_we_i    (dec_take),
    .dec_waddr_i (pi_val),
    .dec_wbit_i  (post_llr_i[LLR_W-1]),
    .dec_raddr_i (cnt_q),
    .dec_rbit_o  (dec_bit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      iter_q  <= '0;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CHECK;
          cnt_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_CHECK: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cnt) begin
            cnt_q  <= '0;
            iter_q <= '0;
            half_q <= 1'b0;
            if (scan_bad) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cnt) begin
            cnt_q   <= '0;
            state_q <= ST_RECV;
          end
        end
        ST_RECV: if (ext_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cnt) begin
            cnt_q <= '0;
            if (!half_q) begin
              half_q  <= 1'b1;
              state_q <= ST_SEND;
            end else if (last_iter) begin
              state_q <= ST_OUT;
            end else begin
              half_q  <= 1'b0;
              iter_q  <= iter_q + 1'b1;
              state_q <= ST_SEND;
            end
          end
        end
        ST_OUT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_cnt) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign perm_err_o  = err_q;
  assign sel_o       = half_q;
  assign ap_valid_o  = state_q == ST_SEND;
  assign ap_idx_o    = cnt_q;
  assign ap_llr_o    = (!half_q && iter_q == '0) ? '0 : mem_rdata;
  assign dec_valid_o = state_q == ST_OUT;
  assign dec_idx_o   = cnt_q;
endmodule

// File: rtl/turbo_iter_ctrl_chk.sv
module turbo_iter_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             perm_err_o,
  input logic             ap_valid_o,
  input logic [IDX_W-1:0] ap_idx_o,
  input logic             dec_valid_o,
  input logic [IDX_W-1:0] dec_idx_o
);
  assert_start_wakes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_err_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_err_o |-> !busy_o);

  assert_ap_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ap_valid_o) |-> ap_idx_o == '0);

  assert_ap_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_valid_o && $past(ap_valid_o)) |-> ap_idx_o == $past(ap_idx_o) + 1'b1);

  assert_dec_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && $past(dec_valid_o)) |-> dec_idx_o == $past(dec_idx_o) + 1'b1);

  assert_one_stream_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ap_valid_o, dec_valid_o}));

  assert_busy_streams_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_valid_o || dec_valid_o) |-> busy_o);
endmodule

bind turbo_iter_ctrl turbo_iter_ctrl_chk #(.IDX_W($clog2(N_LEN))) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .perm_err_o  (perm_err_o),
  .ap_valid_o  (ap_valid_o),
  .ap_idx_o    (ap_idx_o),
  .dec_valid_o (dec_valid_o),
  .dec_idx_o   (dec_idx_o)
);

// File: tb/turbo_iter_ctrl_bench.sv
module turbo_iter_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 16;
  localparam int W  = 8;
  localparam int NI = 6;
  localparam int IW = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic perm_we = 1'b0;
  logic [IW-1:0] perm_addr = '0, perm_data = '0;
  logic start = 1'b0;
  logic busy, perm_err, sel, ap_valid, dec_valid, dec_bit;
  logic [IW-1:0] ap_idx, dec_idx;
  logic [W-1:0] ap_llr;
  logic ext_valid = 1'b0;
  logic [W-1:0] ext_llr = '0, post_llr = '0;

  int perm_m [L];
  logic [W-1:0] mram [L];
  bit dm [L];
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  turbo_iter_ctrl #(.N_LEN(L), .LLR_W(W), .N_ITER(NI)) u_turbo_iter_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .perm_we_i(perm_we), .perm_addr_i(perm_addr), .perm_data_i(perm_data),
    .start_i(start), .busy_o(busy), .perm_err_o(perm_err), .sel_o(sel),
    .ap_valid_o(ap_valid), .ap_idx_o(ap_idx), .ap_llr_o(ap_llr),
    .ext_valid_i(ext_valid), .ext_llr_i(ext_llr), .post_llr_i(post_llr),
    .dec_valid_o(dec_valid), .dec_idx_o(dec_idx), .dec_bit_o(dec_bit)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_entry(int a, int d);
    perm_addr = IW'(a); perm_data = IW'(d); perm_we = 1'b1;
    @(negedge clk);
    perm_we = 1'b0;
  endtask

  task automatic run_half(int it, int h, bit noise, bit gaps, bit disturb);
    logic [W-1:0] e_q[$], p_q[$];
    int guard = 0;
    bit ok = 1;
    while (!ap_valid && guard < 4 * L) begin @(negedge clk); guard++; end
    for (int i = 0; i < L; i++) begin
      logic [W-1:0] exp_ap;
      int v, pv;
      exp_ap = (h == 0) ? ((it == 0) ? '0 : mram[i]) : mram[perm_m[i]];
      if (!(ap_valid && ap_idx == IW'(i) && sel == h[0])) ok = 0;
      if (ap_llr !== exp_ap)
        check(0, h ? "R5 interleaved a priori" : "R4 a priori",
              int'($signed(ap_llr)), int'($signed(exp_ap)));
      v  = (int'($signed(exp_ap)) >>> 1) + ((i * 7 + it * 3 + h * 11) % 31) - 15;
      pv = v + ((i * 5 + it) % 9) - 4;
      e_q.push_back(W'(v));
      p_q.push_back(W'(pv));
      if (noise) begin ext_valid = 1'b1; ext_llr = 8'h55; post_llr = 8'h80; end
      if (disturb && i == 3) begin
        start = 1'b1; perm_we = 1'b1; perm_addr = '0; perm_data = IW'(perm_m[1]);
      end
      @(negedge clk);
      start = 1'b0; perm_we = 1'b0;
    end
    ext_valid = 1'b0;
    check(ok && !ap_valid, "R4 stream of N_LEN beats", int'(ap_valid), 0);
    for (int i = 0; i < L; i++) begin
      if (gaps && (i % 3 == 1)) begin ext_valid = 1'b0; @(negedge clk); end
      ext_valid = 1'b1; ext_llr = e_q[i]; post_llr = p_q[i];
      if (h == 0) mram[i] = e_q[i];
      else mram[perm_m[i]] = e_q[i];
      if (h == 1 && it == NI - 1) dm[perm_m[i]] = p_q[i][W-1];
      @(negedge clk);
    end
    ext_valid = 1'b0;
  endtask

  task automatic run_decode(bit noise, bit gaps, bit disturb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && perm_err == 0, "R2/R3 start accepted, flag cleared", int'(busy), 1);
    for (int i = 1; i < L; i++) @(negedge clk);
    check(busy && !ap_valid, "R2 scan lasts N_LEN cycles", int'(ap_valid), 0);
    @(negedge clk);
    check(ap_valid == 1'b1, "R2 first beat after scan", int'(ap_valid), 1);
    for (int it = 0; it < NI; it++)
      for (int h = 0; h < 2; h++)
        run_half(it, h, noise, gaps, disturb && it == 1 && h == 0);
    check(dec_valid && !ap_valid, "R7 output follows last half", int'(dec_valid), 1);
    for (int i = 0; i < L; i++) begin
      if (!(dec_valid && dec_idx == IW'(i)))
        check(0, "R8 decision index", int'(dec_idx), i);
      check(dec_bit == dm[i], "R8 decision bit", int'(dec_bit), int'(dm[i]));
      @(negedge clk);
    end
    check(!busy && !dec_valid, "R8 busy falls after output", int'(busy), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) begin perm_m[i] = L - 1 - i; mram[i] = '0; dm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !perm_err && !ap_valid && !dec_valid, "R1 reset outputs", int'(busy), 0);
    // R6: return beats while idle are ignored
    ext_valid = 1'b1; ext_llr = 8'h7f;
    @(negedge clk);
    ext_valid = 1'b0;
    check(!busy, "R6 idle return beat ignored", int'(busy), 0);

    // R1 default reversed table, R4-R8 with gaps
    run_decode(0, 1, 0);

    // custom table (i*5+3) mod L
    for (int i = 0; i < L; i++) begin
      perm_m[i] = (i * 5 + 3) % L;
      load_entry(i, perm_m[i]);
    end
    // R6 noise during streams, R9 and R2 disturbance while busy
    run_decode(1, 0, 1);
    // R9: table must be intact, so this run scans clean and matches the model
    run_decode(0, 1, 0);
    check(!perm_err, "R9 table writes while busy ignored", int'(perm_err), 0);

    // R3 duplicate index
    load_entry(5, perm_m[6]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen_ap = 0;
      for (int i = 0; i < L; i++) begin
        if (ap_valid) seen_ap = 1;
        @(negedge clk);
      end
      check(!seen_ap && !busy, "R3 bad table aborts run", int'(busy), 0);
      check(perm_err == 1'b1, "R3 error flag set", int'(perm_err), 1);
    end
    repeat (3) @(negedge clk);
    check(perm_err == 1'b1 && !ap_valid, "R3 flag holds while idle", int'(perm_err), 1);
    load_entry(5, (5 * 5 + 3) % L);
    run_decode(0, 0, 0);
    check(!perm_err, "R3 flag cleared by valid run", int'(perm_err), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule